// File: doc/BRIEF.md
# Serial Memory Target with Persistent Address Pointer

This block is the two-wire serial-bus target in front of a byte-wide memory. The bus clock and data lines arrive as raw levels (`scl_in`, `sda_in`). The block drives the data line only by pulling it low, through `sda_oe`. Inside, both lines pass through synchronisers and an edge detector. A byte engine decodes the device address byte and collects a two-byte word address on writes. It then writes data bytes to an internal synchronous memory, with no write-cycle busy time, or streams data bytes out of that memory.

One address pointer holds its value from one transaction to the next. A write loads the pointer and advances it after each stored byte. A read advances it each time a byte is loaded for output. A read that starts without an address phase therefore continues from the byte after the last one touched. The pointer wraps from its top value to zero. A random read is a write header that sets the pointer, then a repeated START and a read header.

Top module: `serial_mem_target`

## Requirements
- R1: The device address byte is the 7-bit match value (parameter, default 0x50) followed by a direction bit, where 1 means read and 0 means write. A matching byte is acknowledged by pulling SDA low in the 9th clock. A byte that does not match gets no acknowledge, and the target stays silent until the next START.
- R2: A write header is followed by an address high byte, an address low byte and any number of data bytes. The target acknowledges each of them, stores each data byte at the pointer, and then advances the pointer by one.
- R3: A write header with two address bytes, a repeated START and a read header returns data starting at the loaded address.
- R4: In a read, the target drives the MSB of the first byte right after the 9th clock of the read header. Each master acknowledge makes it send the next consecutive byte.
- R5: A read header with no preceding address phase starts at the pointer's current value, which is one past the last byte written or read.
- R6: The pointer wraps from its top value (2^ADDR_W - 1) to 0 for both writes and reads.
- R7: After a master NACK, the target releases SDA from the 9th clock onward and drives nothing on any further clocks.
- R8: A STOP or a START issued during the 9th clock of a read byte ends the read with SDA released. The next read continues at the following address.
- R9: A master NACK in the 9th clock followed by a START in the 10th ends the read. The new header is served normally.
- R10: Address bits above ADDR_W in the address high byte are ignored.
- R11: A START or STOP in the middle of a byte abandons that byte. Memory is not written and the pointer keeps its value.
- R12: After reset, SDA is released and the target is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock level as seen on the wire |
| sda_in | input | 1 | Bus data level as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong pointer value shows up at the ports only on the next read. The bench therefore ends every write-then-read pair with a current-address read, and after each abort or termination it reads the byte it predicts. A state machine that keeps driving after a NACK, STOP or START shows up within one bus clock as a low data line while the master is releasing it. The bench samples the wire in those clocks. A wrap or high-bit error gives a wrong byte in the first read that crosses the boundary.

// File: rtl/sm_pkg.sv
// Shared types for the serial memory target.
// Assumes byte-wide bus transfers with one acknowledge bit per byte.
package sm_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, bus released
        ST_RECV,   // shifting in a byte from the master
        ST_ACK,    // target pulls SDA low for the 9th clock
        ST_SEND,   // shifting out a data byte
        ST_MACK    // 9th clock of a read byte, master answers
    } st_e;

    typedef enum logic [1:0] {
        K_DEV,     // device address and direction
        K_AHI,     // address high byte
        K_ALO,     // address low byte
        K_DATA     // write data byte
    } kind_e;
endpackage

// File: rtl/sm_line_sync.sv
// Synchronises the raw bus lines and reports clock edges and START/STOP.
// Assumes the system clock samples each bus level several times.
module sm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d, scl_q;

    // synchroniser chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_raw};
            sda_sh <= {sda_sh[STAGES-2:0], sda_raw};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_q     = scl_sh[STAGES-1];
    assign sda_q     = sda_sh[STAGES-1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/sm_store.sv
// Synchronous single-port byte memory: write on we, read data one cycle late.
// Assumes the address is held for at least one cycle before read data is used.
module sm_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] cells [DEPTH];

    // array write port
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= cells[addr];
    end
endmodule

// File: rtl/sm_engine.sv
// Byte-level protocol engine: address decode, pointer, acknowledge and data shifting.
// Assumes synchronised line inputs and memory read data valid one cycle after addr.
module sm_engine
    import sm_pkg::*;
#(
    parameter int          ADDR_W   = 11,
    parameter logic [6:0]  DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              sda_oe
);
    localparam int HI_W = ADDR_W - BYTE_W;

    st_e               state;
    kind_e             kind;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [HI_W-1:0]   addr_hi;
    logic [ADDR_W-1:0] latch;
    logic              rd_req;
    logic              mack_seen;

    assign mem_addr = latch;

    // bus protocol sequencing, one action per detected edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= K_DEV;
            bitcnt    <= '0;
            shreg     <= '0;
            addr_hi   <= '0;
            latch     <= '0;
            rd_req    <= 1'b0;
            mack_seen <= 1'b0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
            sda_oe    <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            if (start_det) begin
                state  <= ST_RECV;
                kind   <= K_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RECV: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_q};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            state  <= ST_ACK;
                            sda_oe <= 1'b1;
                            case (kind)
                                K_DEV: begin
                                    if (shreg[7:1] == DEV_ADDR) rd_req <= shreg[0];
                                    else begin
                                        state  <= ST_IDLE;
                                        sda_oe <= 1'b0;
                                    end
                                end
                                K_AHI:   addr_hi <= shreg[HI_W-1:0];
                                K_ALO:   latch   <= {addr_hi, shreg};
                                default: begin
                                    mem_we    <= 1'b1;
                                    mem_wdata <= shreg;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (kind == K_DEV && rd_req) begin
                                shreg  <= mem_rdata;
                                sda_oe <= ~mem_rdata[BYTE_W-1];
                                bitcnt <= 4'd1;
                                latch  <= latch + ADDR_W'(1);
                                state  <= ST_SEND;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RECV;
                                case (kind)
                                    K_DEV:   kind <= K_AHI;
                                    K_AHI:   kind <= K_ALO;
                                    K_ALO:   kind <= K_DATA;
                                    default: latch <= latch + ADDR_W'(1);
                                endcase
                            end
                        end
                    end
                    ST_SEND: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_seen <= ~sda_q;
                        end else if (scl_fall) begin
                            if (mack_seen) begin
                                shreg  <= mem_rdata;
                                sda_oe <= ~mem_rdata[BYTE_W-1];
                                bitcnt <= 4'd1;
                                latch  <= latch + ADDR_W'(1);
                                state  <= ST_SEND;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: a STOP leaves the engine idle with the line released
    a_r11_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R11: a START restarts address decoding with the line released
    a_r11_start_decodes: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RECV && kind == K_DEV && bitcnt == 4'd0 && !sda_oe));

    // R7: the drive changes only after a clock fall or a START/STOP
    a_r7_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R6: each byte loaded for output advances the pointer by one, wrapping
    a_r6_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && $past(state) != ST_SEND) |->
            (latch == $past(latch) + ADDR_W'(1)));
endmodule

// File: rtl/serial_mem_target.sv
// Top level: line synchroniser, protocol engine and the memory array.
// Assumes clk runs at least eight times faster than the bus clock.
module serial_mem_target #(
    parameter int         ADDR_W      = 11,
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    import sm_pkg::*;

    logic              sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic [ADDR_W-1:0] mem_addr;
    logic [BYTE_W-1:0] mem_wdata, mem_rdata;
    logic              mem_we;

    sm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    sm_engine #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .sda_oe(sda_oe)
    );

    sm_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(mem_addr), .wdata(mem_wdata),
        .we(mem_we), .rdata(mem_rdata)
    );
endmodule

// File: tb/serial_mem_target_bench.sv
// Scoreboard bench: bus-master tasks queue expected read bytes, a monitor compares.
module serial_mem_target_bench;
    localparam int         AW  = 11;
    localparam logic [6:0] DEV = 7'h50;
    localparam int         Q   = 32;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_bus;
    assign sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    serial_mem_target #(.ADDR_W(AW), .DEV_ADDR(DEV)) u_serial_mem_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe)
    );

    int total = 0, bad = 0;
    typedef struct { logic [7:0] v; string req; } exp_t;
    exp_t       exp_q[$];
    exp_t       e_cur;
    logic [7:0] obs;
    event       obs_ev;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor: compares each observed read byte with the queued expectation
    initial forever begin
        @(obs_ev);
        if (exp_q.size() == 0) check(1'b0, "R4", "unexpected byte", {24'd0, obs}, 32'd0);
        else begin
            e_cur = exp_q.pop_front();
            check(obs === e_cur.v, e_cur.req, "read byte", {24'd0, obs}, {24'd0, e_cur.v});
        end
    end

    task automatic bus_start;
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q; #Q;
    endtask

    task automatic clock_bit(input logic b, output logic r);
        sda_m = b; #Q; scl_m = 1'b1; #Q; r = sda_bus; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], r);
        clock_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic wr_chk(input logic [7:0] v, input string req);
        bit ack;
        wr_byte(v, ack);
        check(ack, req, "byte acknowledge", {31'd0, ack}, 32'd1);
    endtask

    // mode 0: ack, 1: nack, 2: STOP in 9th clock, 3: START in 9th clock
    task automatic rd_byte(input logic [7:0] expv, input string req, input int mode);
        logic r;
        logic [7:0] d = '0;
        exp_q.push_back('{expv, req});
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, r);
            d = {d[6:0], r};
        end
        case (mode)
            0: clock_bit(1'b0, r);
            1: clock_bit(1'b1, r);
            2: begin sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q; #Q; end
            default: begin sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q; end
        endcase
        obs = d;
        ->obs_ev;
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        bus_start;
        wr_chk({DEV, 1'b0}, req);
        wr_chk(hi, req);
        wr_chk(lo, req);
    endtask

    task automatic read_hdr(input bit with_start, input string req);
        if (with_start) bus_start;
        wr_chk({DEV, 1'b1}, req);
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #400000;
        total++; bad++;
        $display("FAIL R12 watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic r;
        bit   ack, all_hi;
        #1;
        rst_n = 1'b0; #40; rst_n = 1'b1; #40;
        // R12: released bus after reset
        check(sda_oe == 1'b0 && sda_bus == 1'b1, "R12", "reset release", {31'd0, sda_oe}, 32'd0);

        // R2: write header, address 0x010, four data bytes
        set_addr(8'h00, 8'h10, "R2");
        wr_chk(8'h11, "R2"); wr_chk(8'h22, "R2"); wr_chk(8'h33, "R2"); wr_chk(8'h44, "R2");
        bus_stop;

        // R3, R4: random read of three consecutive bytes, last one NACKed
        set_addr(8'h00, 8'h10, "R3");
        read_hdr(1'b1, "R1");
        rd_byte(8'h11, "R3", 0); rd_byte(8'h22, "R4", 0); rd_byte(8'h33, "R4", 1);
        // R7: nothing driven on further clocks after the NACK
        all_hi = 1'b1;
        for (int i = 0; i < 9; i++) begin clock_bit(1'b1, r); all_hi &= r; end
        check(all_hi, "R7", "line high after nack", {31'd0, all_hi}, 32'd1);
        bus_stop;

        // R5: current-address read continues one past the last byte read
        read_hdr(1'b1, "R5");
        rd_byte(8'h44, "R5", 1);
        bus_stop;

        // R1: a non-matching device address is not acknowledged
        bus_start;
        wr_byte({7'h51, 1'b0}, ack);
        check(!ack, "R1", "mismatch ack", {31'd0, ack}, 32'd0);
        bus_stop;

        // R8: STOP during the 9th clock, then START during the 9th clock
        set_addr(8'h00, 8'h10, "R8");
        read_hdr(1'b1, "R8");
        rd_byte(8'h11, "R8", 2);
        check(sda_oe == 1'b0, "R8", "release after stop in 9th", {31'd0, sda_oe}, 32'd0);
        read_hdr(1'b1, "R8");
        rd_byte(8'h22, "R8", 3);
        read_hdr(1'b0, "R8");
        // R9: NACK in the 9th clock then START in the 10th
        rd_byte(8'h33, "R9", 1);
        read_hdr(1'b1, "R9");
        rd_byte(8'h44, "R9", 1);
        bus_stop;

        // R6, R10: write across the top address with junk high bits
        set_addr(8'hFF, 8'hFE, "R10");
        wr_chk(8'hA1, "R6"); wr_chk(8'hA2, "R6"); wr_chk(8'hA3, "R6");
        bus_stop;
        set_addr(8'h07, 8'hFE, "R6");
        read_hdr(1'b1, "R6");
        rd_byte(8'hA1, "R10", 0); rd_byte(8'hA2, "R6", 0); rd_byte(8'hA3, "R6", 1);
        bus_stop;
        set_addr(8'h80, 8'h20, "R10");
        wr_chk(8'h5A, "R10");
        bus_stop;
        set_addr(8'h00, 8'h20, "R10");
        read_hdr(1'b1, "R10");
        rd_byte(8'h5A, "R10", 1);
        bus_stop;

        // R11: a byte cut short by STOP writes nothing and leaves the pointer
        set_addr(8'h00, 8'h30, "R11");
        wr_chk(8'h77, "R11");
        bus_stop;
        set_addr(8'h00, 8'h30, "R11");
        clock_bit(1'b1, r); clock_bit(1'b0, r); clock_bit(1'b0, r); clock_bit(1'b1, r);
        bus_stop;
        read_hdr(1'b1, "R11");
        rd_byte(8'h77, "R11", 1);
        bus_stop;

        #(4 * Q);
        check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule